// File: doc/BRIEF.md
# Snoop Intervention Controller

This block sits beside a small data cache and watches transfers started by another bus master. When such a transfer lands on a cached line that holds modified data, the block stops main memory from answering and takes over as the slave. On a read it returns the cached data: one long word for a single transfer, or the whole four-long-word line for a burst. On a write, when write sinking is enabled, it takes the bus data into the cached line.

The cache array is kept inside the block. It is direct mapped, and each long word carries its own dirty bit. A plain load port writes one long word at a time, together with its dirty flag and the line's tag and valid state. Filling the cache, choosing a victim and the processor-side path are left to neighbouring logic. After each lookup the block can wait an extra 0 to 2 clocks before it acknowledges. The `snp_dly` input sets this wait.

Top module: `snoop_intervene`

## Requirements
- R1: A snooped read intervenes when `snp_mode` is 01 (reads only) or 10 (reads and write sinking), and the line is valid, its tag matches and at least one of its long words is dirty. `mem_inhibit` then goes high in the cycle after the request and stays high through the last acknowledge cycle. It falls in the cycle after that.
- R2: A read intervenes whichever long word of the line is dirty. The addressed long word need not be the dirty one.
- R3: A line read (`snp_size` 11) that intervenes gets four acknowledge cycles in a row. The beats carry long words 0, 1, 2 and 3 of the line, in that order, whatever the address's long-word bits.
- R4: A byte (01), word (10) or long-word (00) read that intervenes gets exactly one acknowledge cycle. That cycle carries the whole addressed long word, selected by address bits [3:2].
- R5: A byte, word or long-word write intervenes only when `snp_mode` is 10 and the line is a dirty hit. It gets exactly one acknowledge cycle, and `snp_wdata` is taken into the line at the end of that cycle.
- R6: The lanes are big-endian. A byte write at offset k (address bits [1:0]) replaces bits [31-8k:24-8k]. A word write with address bit 1 clear replaces bits [31:16], and with bit 1 set replaces bits [15:0]. Every byte not written keeps its value.
- R7: An intervened write sets the dirty bit of the long word it wrote.
- R8: The first acknowledge comes d+1 cycles after `mem_inhibit` rises. d is `snp_dly` for codes 0 to 2, and code 3 counts as 2.
- R9: None of `mem_inhibit`, `xfer_ack` or `rdata_oe` is asserted in any of these cases: a miss, a hit to a line with no dirty long word, `snp_mode` 00 or 11, or a write while `snp_mode` is 01. All three outputs are also low after reset.
- R10: `rdata_oe` is high exactly in the acknowledge cycles of an intervened read, and low in the cycle after the last one.
- R11: A request that arrives while an intervention is in progress is ignored. It does not change the timing or the data of the transfer in progress.
- R12: A line write (`snp_size` 11 with `snp_rd` low) is never intervened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| snp_start | input | 1 | One-cycle strobe marking a snooped transfer |
| snp_addr | input | AW | Snooped byte address: tag, set, long word [3:2], byte [1:0] |
| snp_size | input | 2 | 00 long, 01 byte, 10 word, 11 line |
| snp_rd | input | 1 | 1 = read, 0 = write |
| snp_wdata | input | 32 | Write data from the other master, held until acknowledged |
| snp_mode | input | 2 | 00 off, 01 reads, 10 reads and sink writes, 11 off |
| snp_dly | input | 2 | Extra lookup clocks before the first acknowledge (3 acts as 2) |
| ld_en | input | 1 | Load one long word into the array |
| ld_set | input | IW | Set to load |
| ld_tag | input | TW | Tag to store for that set |
| ld_lw | input | 2 | Long word within the line |
| ld_data | input | 32 | Long-word data |
| ld_dirty | input | 1 | Dirty flag for that long word |
| ld_valid | input | 1 | Valid flag for the line |
| mem_inhibit | output | 1 | Holds main memory off the transfer |
| xfer_ack | output | 1 | Transfer acknowledge, one per beat |
| rdata | output | 32 | Read data supplied to the bus |
| rdata_oe | output | 1 | Data bus output enable |

## Verification
A wrong lookup decision shows in the first cycle after the request, as `mem_inhibit` wrongly high or wrongly low. A wrong delay count moves the first `xfer_ack` by whole cycles, a wrong beat counter breaks the ascending order or the four-beat run of a line read, and a wrong lane decode corrupts only certain bytes. Errors in the array stay hidden until later. A bad merge or a lost dirty bit shows only on a later intervened read of that line: wrong bytes in `rdata`, or no intervention at all where one is due. The bench therefore reads each written line back as a burst right after the write.

// File: rtl/snoop_intervene.sv
module snoop_intervene #(
  parameter int AW      = 16,
  parameter int SETS    = 4,
  parameter int MAX_DLY = 2,
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TW = AW - 4 - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_start,
  input  logic [AW-1:0] snp_addr,
  input  logic [1:0]    snp_size,
  input  logic          snp_rd,
  input  logic [31:0]   snp_wdata,
  input  logic [1:0]    snp_mode,
  input  logic [1:0]    snp_dly,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_set,
  input  logic [TW-1:0] ld_tag,
  input  logic [1:0]    ld_lw,
  input  logic [31:0]   ld_data,
  input  logic          ld_dirty,
  input  logic          ld_valid,
  output logic          mem_inhibit,
  output logic          xfer_ack,
  output logic [31:0]   rdata,
  output logic          rdata_oe
);

  localparam logic [1:0] SZ_LINE = 2'b11;

  typedef enum logic [1:0] {IDLE, LOOK, XFER} st_t;
  st_t st;

  logic [31:0]   dat [SETS][4];
  logic [3:0]    drt [SETS];
  logic [TW-1:0] tg  [SETS];
  logic [SETS-1:0] vld;

  logic [IW-1:0] q_set;
  logic [1:0]    q_lw, q_size, cnt, beat;
  logic [3:0]    q_be;
  logic          q_rd;

  wire [IW-1:0] a_set = snp_addr[4 +: IW];
  wire [TW-1:0] a_tag = snp_addr[AW-1 -: TW];
  wire [1:0]    a_lw  = snp_addr[3:2];

  logic [3:0] a_be;
  always_comb
    case (snp_size)
      2'b01:   a_be = 4'b1000 >> snp_addr[1:0];
      2'b10:   a_be = snp_addr[1] ? 4'b0011 : 4'b1100;
      default: a_be = 4'b1111;
    endcase

  wire dirty_hit = vld[a_set] && (tg[a_set] == a_tag) && (|drt[a_set]);
  wire rd_on     = (snp_mode == 2'b01) || (snp_mode == 2'b10);
  wire wr_on     = (snp_mode == 2'b10) && (snp_size != SZ_LINE);
  wire take      = (st == IDLE) && snp_start && dirty_hit && (snp_rd ? rd_on : wr_on);
  wire [1:0] dly_c = (snp_dly > 2'(MAX_DLY)) ? 2'(MAX_DLY) : snp_dly;
  wire burst     = q_rd && (q_size == SZ_LINE);
  wire last      = !burst || (beat == 2'd3);
  wire sink      = (st == XFER) && !q_rd;

  assign mem_inhibit = (st != IDLE);
  assign xfer_ack    = (st == XFER);
  assign rdata_oe    = (st == XFER) && q_rd;
  assign rdata       = dat[q_set][burst ? beat : q_lw];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      q_set  <= '0;
      q_lw   <= '0;
      q_size <= '0;
      q_be   <= '0;
      q_rd   <= 1'b0;
      cnt    <= '0;
      beat   <= '0;
    end else
      case (st)
        IDLE: if (take) begin
          st     <= LOOK;
          q_set  <= a_set;
          q_lw   <= a_lw;
          q_size <= snp_size;
          q_be   <= a_be;
          q_rd   <= snp_rd;
          cnt    <= dly_c;
          beat   <= '0;
        end
        LOOK: if (cnt == 2'd0) st <= XFER;
              else cnt <= cnt - 2'd1;
        XFER: if (last) st <= IDLE;
              else beat <= beat + 2'd1;
        default: st <= IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < SETS; s++) drt[s] <= '0;
    end else if (sink) begin
      drt[q_set][q_lw] <= 1'b1;
    end else if (ld_en) begin
      drt[ld_set][ld_lw] <= ld_dirty;
      vld[ld_set]        <= ld_valid;
    end

  always_ff @(posedge clk)
    if (sink) begin
      for (int b = 0; b < 4; b++)
        if (q_be[b]) dat[q_set][q_lw][8*b +: 8] <= snp_wdata[8*b +: 8];
    end else if (ld_en) begin
      dat[ld_set][ld_lw] <= ld_data;
      tg[ld_set]         <= ld_tag;
    end

  assert_ack_under_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> mem_inhibit);

  assert_mode_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && snp_start && (snp_mode == 2'b00 || snp_mode == 2'b11)) |=> !mem_inhibit);

  assert_delay_holds_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOK && cnt != 2'd0) |=> (!xfer_ack && mem_inhibit));

  assert_burst_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && burst && beat != 2'd3) |=> (xfer_ack && beat == 2'($past(beat) + 2'd1)));

  assert_write_one_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !q_rd) |=> !xfer_ack);

  assert_sink_sets_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !q_rd) |=> drt[q_set][q_lw]);

  assert_oe_drops_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_ack) |-> !rdata_oe);

endmodule

// File: tb/sim_snoop_intervene.sv
module sim_snoop_intervene;
  localparam int AW = 16, SETS = 4, IW = 2, TW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          snp_start = 0, snp_rd = 0, ld_en = 0, ld_dirty = 0, ld_valid = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [1:0]    snp_size = 0, snp_mode = 0, snp_dly = 0, ld_lw = 0;
  logic [31:0]   snp_wdata = 0, ld_data = 0;
  logic [IW-1:0] ld_set = 0;
  logic [TW-1:0] ld_tag = 0;
  logic          mem_inhibit, xfer_ack, rdata_oe;
  logic [31:0]   rdata;

  snoop_intervene #(.AW(AW), .SETS(SETS), .MAX_DLY(2)) u0 (.*);

  int nchk = 0, nerr = 0;
  logic [31:0]   md  [SETS][4];
  logic [3:0]    mdt [SETS];
  logic [TW-1:0] mtg [SETS];
  logic          mv  [SETS];

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic load(int s, logic [TW-1:0] t, int lw, logic [31:0] d, bit dy, bit v);
    @(negedge clk);
    ld_en = 1; ld_set = IW'(s); ld_tag = t; ld_lw = 2'(lw); ld_data = d; ld_dirty = dy; ld_valid = v;
    @(negedge clk);
    ld_en = 0;
    md[s][lw] = d; mdt[s][lw] = dy; mtg[s] = t; mv[s] = v;
  endtask

  task automatic fill(int s, logic [TW-1:0] t, logic [3:0] dmask, int seed);
    for (int w = 0; w < 4; w++)
      load(s, t, w, 32'(seed) * 32'h01030507 ^ (32'(w) << 4) ^ 32'h5A3C0F00, dmask[w], 1'b1);
  endtask

  function automatic logic [15:0] mkaddr(logic [TW-1:0] t, int s, int lw, int off);
    return {t, 2'(s), 2'(lw), 2'(off)};
  endfunction

  task automatic snoop(logic [AW-1:0] a, logic [1:0] sz, bit rd, logic [31:0] wd,
                       logic [1:0] mode, logic [1:0] dl, bit poke, string lab);
    int s = int'(a[5:4]), lw = int'(a[3:2]);
    bit hit = mv[s] && (mtg[s] == a[15:6]) && (mdt[s] != 0);
    bit iv = hit && (rd ? (mode == 2'b01 || mode == 2'b10) : (mode == 2'b10 && sz != 2'b11));
    int beats = (rd && sz == 2'b11) ? 4 : 1;
    int de = (dl == 2'd3) ? 2 : int'(dl);
    logic [3:0] be;
    string rm, rt, rd_l, ro;
    rm = iv ? "R1" : (!rd && sz == 2'b11) ? "R12" : "R9";
    rt = iv ? "R8" : rm;
    ro = iv ? "R10" : rm;
    rd_l = (sz == 2'b11) ? "R3" : "R4";
    if (lab != "") begin rm = lab; rt = lab; ro = lab; rd_l = lab; end
    @(negedge clk);
    snp_start = 1; snp_addr = a; snp_size = sz; snp_rd = rd; snp_wdata = wd;
    snp_mode = mode; snp_dly = dl;
    @(negedge clk);
    snp_start = 0;
    for (int i = 0; i < 12; i++) begin
      bit em = iv && i <= de + beats;
      bit et = iv && i >= de + 1 && i <= de + beats;
      chk(mem_inhibit == em, rm, 32'(mem_inhibit), 32'(em));
      chk(xfer_ack == et, rt, 32'(xfer_ack), 32'(et));
      chk(rdata_oe == (et && rd), ro, 32'(rdata_oe), 32'(et && rd));
      if (et && rd) begin
        logic [31:0] ed = (sz == 2'b11) ? md[s][i - de - 1] : md[s][lw];
        chk(rdata == ed, rd_l, rdata, ed);
      end
      if (poke && i == 1) snp_start = 1;
      if (poke && i == 2) snp_start = 0;
      @(negedge clk);
    end
    if (iv && !rd) begin
      case (sz)
        2'b01:   be = 4'b1000 >> a[1:0];
        2'b10:   be = a[1] ? 4'b0011 : 4'b1100;
        default: be = 4'b1111;
      endcase
      for (int b = 0; b < 4; b++) if (be[b]) md[s][lw][8*b +: 8] = wd[8*b +: 8];
      mdt[s][lw] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin mv[s] = 0; mdt[s] = 0; mtg[s] = 0; end
    repeat (3) @(negedge clk);
    chk(!mem_inhibit && !xfer_ack && !rdata_oe, "R9 reset",
        {29'd0, mem_inhibit, xfer_ack, rdata_oe}, 0);
    rst_n = 1;

    // read sweep: R1 R2 R3 R4 R8 R9 R10
    for (int dp = 0; dp < 5; dp++) begin
      fill(1, 10'h155, (dp < 4) ? 4'(1 << dp) : 4'b0000, dp + 3);
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 4; d++)
          for (int sz = 0; sz < 4; sz++)
            for (int hm = 0; hm < 2; hm++)
              snoop(mkaddr(hm ? 10'h0AA : 10'h155, 1, (dp + 1) % 4, m), 2'(sz), 1'b1,
                    32'h0, 2'(m), 2'(d), 1'b0, (dp < 4 && hm == 0 && m == 1) ? "R2" : "");
    end

    // write sweep with burst readback: R5 R6 R12 R9
    for (int m = 0; m < 4; m++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int d = 0; d < 3; d++) begin
            fill(2, 10'h2C3, 4'b0001, m * 16 + sz * 4 + off);
            snoop(mkaddr(10'h2C3, 2, 2, off), 2'(sz), 1'b0,
                  32'hF1E2D3C4 ^ 32'(m << 8 | sz << 4 | off), 2'(m), 2'(d), 1'b0,
                  (m == 2 && sz != 3) ? "R5" : "");
            snoop(mkaddr(10'h2C3, 2, 0, 0), 2'b11, 1'b1, 32'h0, 2'b01, 2'd0, 1'b0, "R6");
          end

    // R7: only the sunk long word remains dirty, yet a read still intervenes
    fill(3, 10'h0F0, 4'b0001, 77);
    snoop(mkaddr(10'h0F0, 3, 2, 0), 2'b00, 1'b0, 32'hCAFE1234, 2'b10, 2'd1, 1'b0, "R7");
    load(3, 10'h0F0, 0, md[3][0], 1'b0, 1'b1);
    snoop(mkaddr(10'h0F0, 3, 1, 0), 2'b00, 1'b1, 32'h0, 2'b01, 2'd0, 1'b0, "R7");
    snoop(mkaddr(10'h0F0, 3, 0, 0), 2'b11, 1'b1, 32'h0, 2'b10, 2'd0, 1'b0, "R7");

    // R11: a second strobe during a busy burst is ignored
    fill(0, 10'h011, 4'b1000, 9);
    snoop(mkaddr(10'h011, 0, 1, 0), 2'b11, 1'b1, 32'h0, 2'b10, 2'd2, 1'b1, "R11");
    snoop(mkaddr(10'h011, 0, 3, 0), 2'b00, 1'b1, 32'h0, 2'b01, 2'd3, 1'b1, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule